// File: doc/BRIEF.md
# Local Countdown Timer with Prescaler

This block is a per-processor countdown timer. A bus clock feeds a power-of-two prescaler, and the prescaler's ticks decrement a current-count register. Software programs the block through a simple register write port. It sets a divide code, a timer vector-table entry and an initial count. Writing the initial count starts a countdown. The countdown then either stops at zero (one-shot) or reloads and runs again (periodic).

Expiries are not kept as a single flag. Each one adds to a small saturating pending counter. An interrupt request is raised while that counter is nonzero and the timer entry is unmasked. Each acknowledge strobe taken while the request is high consumes one pending expiry.

A control register carries a software-enable bit. Clearing it masks every vector-table entry and discards pending expiries. While the block is disabled, any entry write is stored with its mask set.

Top module: `lct_timer`

## Requirements
- R1: After reset: the control register reads 0, the initial count, current count and divide code read 0, every entry reads 0x00010000 (mask set), and `irq_req` is 0.
- R2: The divide code is written at address 0x3. Its bits {3,1,0} form a 3-bit value v. The prescaler divides by 2^((v+1) mod 8), so code 0x0 divides by 2, code 0xB divides by 1 and code 0xA divides by 128. Bit 2 has no effect. A one-shot expiry occurs exactly initial-count × divisor cycles after the initial-count write.
- R3: Writing an initial count of 0 (address 0x1) stops the timer. The current count (address 0x2) reads 0 and no expiry follows.
- R4: In one-shot mode (entry bit 17 = 0), the current count stays at 0 after expiry until the next initial-count write.
- R5: In periodic mode (entry bit 17 = 1), the count reloads from the initial count on the tick that reaches 0. Expiries therefore repeat every initial-count × divisor cycles.
- R6: An initial-count write cancels the running countdown, loads the new value into the current count, and zeroes the pending count.
- R7: `irq_req` is 1 exactly when the timer entry (address 0x8) has its mask bit 16 clear and the pending count is nonzero. An `ack` while `irq_req` is 1 decrements the pending count by one. `irq_vector` is entry bits 7:0.
- R8: Writing the control register (address 0x0) with bit 8 = 0 sets the mask bit in every entry (addresses 0x8 upward) and zeroes the pending count.
- R9: While bit 8 of the control register is 0, entry writes are stored with bit 16 forced to 1. Only the timer entry (address 0x8) keeps bit 17. Other entries store only bits 7:0 and 16.
- R10: The prescaler restarts from zero on every initial-count or divide-code write.
- R11: The pending count saturates at 2^PEND_W − 1 (7 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| ack | input | 1 | Interrupt delivery acknowledge |
| irq_req | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Vector of the timer entry |

## Verification
Several behaviours are checked by the bound checker on every cycle:
- a load sets the current count and clears the pending count;
- a zero count stays at zero;
- the count never steps by more than one except on load;
- each expiry and each taken acknowledge move the pending count by exactly one;
- a disable write or a disabled entry write leaves the timer entry masked.

Other behaviours only show up in the bench's scenarios, because they depend on timing or history:
- the exact expiry latency for every divide code;
- the periodic reload spacing;
- the prescaler restart on a divide write;
- saturation of the pending count.

// File: rtl/lct_pkg.sv
`timescale 1ns/1ps
package lct_pkg;

    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 4;
    localparam int VEC_W        = 8;
    localparam int SHIFT_W      = 3;
    localparam int CTRL_EN_BIT  = 8;
    localparam int ENT_MASK_BIT = 16;
    localparam int ENT_PER_BIT  = 17;

    localparam logic [ADDR_W-1:0] ADR_CTRL     = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_INIT     = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_CUR      = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_DIV      = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_ENT_BASE = 4'h8;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vec;
    } lvt_ent_t;

    localparam lvt_ent_t ENT_RESET = '{periodic: 1'b0, masked: 1'b1, vec: '0};

    // Shuffled divide code: bits {3,1,0}, plus one, modulo eight.
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] code);
        logic [SHIFT_W-1:0] sel;
        sel = {code[3], code[1], code[0]};
        return sel + 3'd1;
    endfunction

    function automatic lvt_ent_t ent_pack(input logic [DATA_W-1:0] w,
                                          input logic keep_per,
                                          input logic force_mask);
        lvt_ent_t e;
        e.vec      = w[VEC_W-1:0];
        e.masked   = w[ENT_MASK_BIT] | force_mask;
        e.periodic = keep_per & w[ENT_PER_BIT];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] ent_word(input lvt_ent_t e);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[VEC_W-1:0]    = e.vec;
        w[ENT_MASK_BIT] = e.masked;
        w[ENT_PER_BIT]  = e.periodic;
        return w;
    endfunction

endpackage

// File: rtl/lct_prescaler.sv
`timescale 1ns/1ps
module lct_prescaler
    import lct_pkg::*;
#(
    parameter int SEL_W = SHIFT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [SEL_W-1:0] shift,
    output logic             tick
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic [PS_W-1:0] cnt_q;
    logic [PS_W-1:0] limit;

    assign limit = ~({PS_W{1'b1}} << shift);
    assign tick  = run & ~restart & (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lct_countdown.sv
`timescale 1ns/1ps
module lct_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             tick,
    output logic [CNT_W-1:0] cur,
    output logic             active,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign active = (cur != '0);
    assign expire = tick & ~load & (cur == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (tick && active) begin
            if (cur == ONE) begin
                cur <= periodic ? reload_val : '0;
            end else begin
                cur <= cur - ONE;
            end
        end
    end
endmodule

// File: rtl/lct_pending.sv
`timescale 1ns/1ps
module lct_pending #(
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] count,
    output logic              nonzero
);
    localparam logic [PEND_W-1:0] FULL = '1;

    assign nonzero = (count != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (count != FULL) count <= count + 1'b1;
                2'b01:   if (nonzero)       count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/lct_timer.sv
`timescale 1ns/1ps
module lct_timer
    import lct_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PEND_W  = 3,
    parameter int NUM_ENT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector
);
    logic              ctrl_en;
    logic [CNT_W-1:0]  init_q;
    logic [3:0]        div_q;
    lvt_ent_t          ents [NUM_ENT];
    lvt_ent_t          tmr_ent;
    logic              tmr_masked;

    logic              ctrl_wr, init_wr, div_wr, ent0_wr, disable_evt;
    logic              tick, cnt_active, expire, pend_nz, take;
    logic [CNT_W-1:0]  cur_cnt;
    logic [PEND_W-1:0] pend_cnt;

    assign ctrl_wr     = wr_en && (wr_addr == ADR_CTRL);
    assign init_wr     = wr_en && (wr_addr == ADR_INIT);
    assign div_wr      = wr_en && (wr_addr == ADR_DIV);
    assign ent0_wr     = wr_en && (wr_addr == ADR_ENT_BASE);
    assign disable_evt = ctrl_wr && !wr_data[CTRL_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en <= 1'b0;
            init_q  <= '0;
            div_q   <= '0;
        end else begin
            if (ctrl_wr) ctrl_en <= wr_data[CTRL_EN_BIT];
            if (init_wr) init_q  <= wr_data[CNT_W-1:0];
            if (div_wr)  div_q   <= wr_data[3:0];
        end
    end

    // One register per vector-table entry; entry 0 is the timer entry.
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        lvt_ent_t q;
        logic     hit;
        assign hit = wr_en && (wr_addr == ADR_ENT_BASE + ADDR_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= ENT_RESET;
            end else if (disable_evt) begin
                q.masked <= 1'b1;
            end else if (hit) begin
                q <= ent_pack(wr_data, (g == 0), !ctrl_en);
            end
        end
        assign ents[g] = q;
    end

    assign tmr_ent    = ents[0];
    assign tmr_masked = tmr_ent.masked;

    lct_prescaler #(.SEL_W(SHIFT_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (init_wr | div_wr),
        .run     (cnt_active),
        .shift   (div_shift(div_q)),
        .tick    (tick)
    );

    lct_countdown #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (init_wr),
        .load_val   (wr_data[CNT_W-1:0]),
        .reload_val (init_q),
        .periodic   (tmr_ent.periodic),
        .tick       (tick),
        .cur        (cur_cnt),
        .active     (cnt_active),
        .expire     (expire)
    );

    assign take = ack & irq_req;

    lct_pending #(.PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .clear   (init_wr | disable_evt),
        .inc     (expire),
        .dec     (take),
        .count   (pend_cnt),
        .nonzero (pend_nz)
    );

    assign irq_req    = ~tmr_masked & pend_nz;
    assign irq_vector = tmr_ent.vec;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_CTRL) rd_data[CTRL_EN_BIT] = ctrl_en;
        if (rd_addr == ADR_INIT) rd_data = DATA_W'(init_q);
        if (rd_addr == ADR_CUR)  rd_data = DATA_W'(cur_cnt);
        if (rd_addr == ADR_DIV)  rd_data[3:0] = div_q;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (rd_addr == ADR_ENT_BASE + ADDR_W'(i)) rd_data = ent_word(ents[i]);
        end
    end
endmodule

// File: rtl/lct_timer_chk.sv
`timescale 1ns/1ps
module lct_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              init_wr,
    input logic [CNT_W-1:0]  load_val,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic [PEND_W-1:0] pend_cnt,
    input logic              expire,
    input logic              ack,
    input logic              irq_req,
    input logic              tmr_masked,
    input logic              disable_evt,
    input logic              ent0_wr,
    input logic              ctrl_en
);
    localparam logic [PEND_W-1:0] FULL = '1;

    a_r6_load_restarts: assert property (@(posedge clk) disable iff (rst)
        init_wr |=> (cur_cnt == $past(load_val)) && (pend_cnt == '0));

    a_r4_zero_sticks: assert property (@(posedge clk) disable iff (rst)
        (cur_cnt == '0 && !init_wr) |=> cur_cnt == '0);

    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        (!init_wr && cur_cnt > CNT_W'(1)) |=>
            (cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    a_r11_expiry_counts: assert property (@(posedge clk) disable iff (rst)
        (expire && !init_wr && !disable_evt && !(ack && irq_req) && pend_cnt != FULL)
            |=> pend_cnt == PEND_W'($past(pend_cnt) + 1'b1));

    a_r7_ack_consumes: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_req && !expire && !init_wr && !disable_evt)
            |=> pend_cnt == PEND_W'($past(pend_cnt) - 1'b1));

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        disable_evt |=> (pend_cnt == '0) && tmr_masked && !irq_req);

    a_r9_locked_mask: assert property (@(posedge clk) disable iff (rst)
        (ent0_wr && !ctrl_en) |=> tmr_masked);
endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .init_wr     (init_wr),
    .load_val    (wr_data[CNT_W-1:0]),
    .cur_cnt     (cur_cnt),
    .pend_cnt    (pend_cnt),
    .expire      (expire),
    .ack         (ack),
    .irq_req     (irq_req),
    .tmr_masked  (tmr_masked),
    .disable_evt (disable_evt),
    .ent0_wr     (ent0_wr),
    .ctrl_en     (ctrl_en)
);

// File: tb/lct_timer_bench.sv
`timescale 1ns/1ps
module lct_timer_bench;
    import lct_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              ack = 1'b0;
    logic              irq_req;
    logic [VEC_W-1:0]  irq_vector;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #10 clk = ~clk;

    lct_timer u_lct_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ack(ack),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    localparam int NROWS = 9;
    localparam logic [3:0] T_DIV [NROWS] = '{4'hB, 4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'h4};
    localparam int T_INIT [NROWS] = '{5, 3, 2, 2, 1, 1, 1, 1, 4};
    localparam int T_LAT  [NROWS] = '{5, 6, 8, 16, 16, 32, 64, 128, 8};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic ack_once(input string req);
        chk(req, 32'(irq_req), 32'd1);
        ack = 1'b1;
        @(posedge clk); #1;
        ack = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int k;
        edges(3);
        rst = 1'b0;
        edges(1);

        // R1 reset state
        rd(ADR_CTRL, v);     chk("R1 ctrl", v, 32'h0);
        rd(ADR_CUR, v);      chk("R1 cur", v, 32'h0);
        rd(ADR_INIT, v);     chk("R1 init", v, 32'h0);
        rd(ADR_DIV, v);      chk("R1 div", v, 32'h0);
        rd(ADR_ENT_BASE, v); chk("R1 timer entry", v, 32'h0001_0000);
        rd(4'h9, v);         chk("R1 aux entry", v, 32'h0001_0000);
        chk("R1 irq", 32'(irq_req), 32'd0);

        // R9 writes while disabled keep the mask
        wr(ADR_ENT_BASE, 32'h0002_0033);
        rd(ADR_ENT_BASE, v); chk("R9 timer entry disabled", v, 32'h0003_0033);
        wr(4'h9, 32'h0002_0044);
        rd(4'h9, v);         chk("R9 aux entry disabled", v, 32'h0001_0044);
        wr(ADR_CTRL, 32'h100);
        wr(4'h9, 32'h0000_0044);
        rd(4'h9, v);         chk("R9 aux entry enabled", v, 32'h0000_0044);

        // R2 / R4 / R7 table of divide codes
        for (int r = 0; r < NROWS; r++) begin
            wr(ADR_DIV, {28'h0, T_DIV[r]});
            wr(ADR_ENT_BASE, 32'h0000_0020);
            wr(ADR_INIT, 32'(T_INIT[r]));
            k = 0;
            while (!irq_req && k < 400) begin
                @(posedge clk); #1; k++;
            end
            chk("R2 expiry latency", 32'(k), 32'(T_LAT[r]));
            chk("R7 vector", 32'(irq_vector), 32'h20);
            rd(ADR_CUR, v); chk("R4 cur at expiry", v, 32'h0);
            edges(5);
            rd(ADR_CUR, v); chk("R4 cur sticks", v, 32'h0);
            ack_once("R7 irq before ack");
            chk("R7 irq after ack", 32'(irq_req), 32'd0);
        end

        // R3 zero initial count stops the timer
        wr(ADR_DIV, 32'hB);
        wr(ADR_INIT, 32'd100);
        edges(3);
        wr(ADR_INIT, 32'd0);
        rd(ADR_CUR, v); chk("R3 cur after zero", v, 32'h0);
        edges(150);
        chk("R3 no expiry", 32'(irq_req), 32'd0);
        rd(ADR_CUR, v); chk("R3 cur stays zero", v, 32'h0);

        // R5 periodic reload, pending accumulates while masked
        wr(ADR_ENT_BASE, 32'h0003_0021);
        wr(ADR_INIT, 32'd10);
        edges(4);
        rd(ADR_CUR, v); chk("R5 cur counting", v, 32'd6);
        edges(26);
        rd(ADR_CUR, v); chk("R5 cur reloaded", v, 32'd10);
        chk("R7 masked no irq", 32'(irq_req), 32'd0);
        wr(ADR_ENT_BASE, 32'h0002_0021);
        ack_once("R5 pending 3");
        ack_once("R5 pending 2");
        ack_once("R5 pending 1");
        chk("R5 three expiries consumed", 32'(irq_req), 32'd0);
        ack = 1'b1; edges(1); ack = 1'b0;
        chk("R7 ack ignored when idle", 32'(irq_req), 32'd0);
        edges(5);
        chk("R5 fourth expiry", 32'(irq_req), 32'd1);

        // R6 initial-count write cancels and clears pending
        wr(ADR_INIT, 32'd7);
        chk("R6 pending cleared", 32'(irq_req), 32'd0);
        rd(ADR_CUR, v); chk("R6 new count", v, 32'd7);

        // R10 divide write restarts the prescaler
        wr(ADR_ENT_BASE, 32'h0000_0022);
        wr(ADR_DIV, 32'h0);
        wr(ADR_INIT, 32'd2);
        edges(3);
        wr(ADR_DIV, 32'h0);
        chk("R10 no early expiry", 32'(irq_req), 32'd0);
        edges(1);
        chk("R10 still waiting", 32'(irq_req), 32'd0);
        edges(1);
        chk("R10 expiry after restart", 32'(irq_req), 32'd1);
        ack_once("R10 consume");

        // R11 pending saturation
        wr(ADR_ENT_BASE, 32'h0003_0055);
        wr(ADR_DIV, 32'hB);
        wr(ADR_INIT, 32'd1);
        edges(20);
        wr(ADR_ENT_BASE, 32'h0000_0055);
        edges(1);
        rd(ADR_CUR, v); chk("R4 one-shot after periodic", v, 32'h0);
        chk("R7 vector 55", 32'(irq_vector), 32'h55);
        for (int i = 0; i < 7; i++) ack_once("R11 saturated pending");
        chk("R11 saturated at seven", 32'(irq_req), 32'd0);

        // R8 disable masks all entries and zeroes pending
        wr(ADR_ENT_BASE, 32'h0000_0021);
        wr(ADR_INIT, 32'd2);
        edges(2);
        chk("R8 irq before disable", 32'(irq_req), 32'd1);
        wr(ADR_CTRL, 32'h0);
        chk("R8 irq after disable", 32'(irq_req), 32'd0);
        rd(ADR_ENT_BASE, v); chk("R8 timer entry masked", v, 32'h0001_0021);
        rd(4'h9, v);         chk("R8 aux entry masked", v, 32'h0001_0044);
        wr(ADR_CTRL, 32'h100);
        wr(ADR_ENT_BASE, 32'h0000_0021);
        chk("R8 pending was zeroed", 32'(irq_req), 32'd0);

        finish_run();
    end
endmodule